// File: doc/BRIEF.md
# Backup Power Switchover Controller

This block chooses whether the RAM supply rail is fed from the main supply or from a backup source such as a battery or storage capacitor. It works on digitized codes: a main-supply code, a backup-voltage code and a power-fail sense code, each sampled every clock, for example from an ADC. It compares them against threshold and reference codes with hysteresis. From the results it drives two complementary switch-enable pairs, one for the main path and one for the backup path, plus a backup-mode flag for the reset and watchdog logic and a power-fail output.

The controller enters backup only when two things are true at once: the main supply has dropped below the reset threshold, and it is also below the backup voltage. It leaves backup as soon as the main supply climbs back over the threshold, whatever the backup voltage does. A backup input that reads near zero because it floats or is grounded cannot start a switchover. Every change of path is break-before-make. While backup mode is active, the power-fail comparator is frozen and its output is held low.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: During and after synchronous reset, the main pair is closed (`main_sw_en` all ones), the backup pair is open (`bat_sw_en` all zeros), `backup_mode` is 0 and `pf_n` is 1.
- R2: Backup mode is entered only when `vcc_code < RST_TH` and `vcc_code + SW_HALF < vbat_code` and `vbat_code >= BATT_MIN`. The flag rises two clock edges after the inputs are presented, and the backup pair closes on the third edge.
- R3: With `vcc_code` below `RST_TH` but not below the backup voltage by more than `SW_HALF`, the main pair stays closed and `backup_mode` stays 0.
- R4: In backup mode, `vcc_code >= RST_TH + RST_HYS` returns the block to the main supply, whatever `vbat_code` is, including 0.
- R5: In backup mode, a `vcc_code` in the band from `RST_TH` to `RST_TH + RST_HYS - 1` keeps the block in backup.
- R6: The switchover comparison has hysteresis of `SW_HALF` codes on each side of the crossing. With `vcc_code + SW_HALF == vbat_code` there is no entry. One code more of backup voltage gives entry.
- R7: Break-before-make: in each direction the block spends exactly one cycle with both pairs open (all enables 0) before the new pair closes.
- R8: `backup_mode` is 1 from the break cycle on the way into backup until the break cycle on the way out, where it is already 0.
- R9: Outside backup mode, `pf_n` goes to 0 when `pf_code < PF_REF` and returns to 1 only when `pf_code >= PF_REF + PF_HYS`. It follows the input two edges after the input changes.
- R10: While `backup_mode` is 1, `pf_n` is 0 whatever `pf_code` is.
- R11: A backup code below `BATT_MIN` (floating or grounded input) never causes a switchover, even with the main supply below threshold. With the main supply above threshold, no backup code causes one.
- R12: The main pair and the backup pair are never closed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_code | input | CODE_W | Digitized main supply |
| vbat_code | input | CODE_W | Digitized backup voltage |
| pf_code | input | CODE_W | Digitized power-fail sense input |
| main_sw_en | output | NSW | Main-path switch enables, 1 = closed |
| bat_sw_en | output | NSW | Backup-path switch enables, 1 = closed |
| backup_mode | output | 1 | 1 while the rail is switching to or running from backup |
| pf_n | output | 1 | Power-fail output, active low |

## Verification
The bench targets the edges of each hysteresis band. A design that compared the reset threshold without hysteresis would drop out of backup with the main supply a few codes over the threshold. One that ignored the switchover margin would enter backup at exact equality plus the margin. The bench drives a grounded or floating-low backup code with the main supply collapsed, which catches a design that switches onto a dead source. It also samples every cycle of both transitions. A design that skipped the open cycle, or that held backup when the main supply recovered with the backup code at zero, would show the wrong enable pattern on a specific edge. The power-fail output is driven high-side inputs during backup to catch a comparator that is not overridden.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    ST_MAIN     = 2'd0,
    ST_BRK_BAT  = 2'd1,
    ST_BATT     = 2'd2,
    ST_BRK_MAIN = 2'd3
  } sw_state_e;
endpackage

// File: rtl/bkup_hyst_cmp.sv
// Registered "below" comparator with hysteresis.
// Sets when val + LO_OFS < ref_code, clears when val >= ref_code + HI_OFS.
module bkup_hyst_cmp #(
  parameter int W      = 10,
  parameter int LO_OFS = 0,
  parameter int HI_OFS = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] val,
  input  logic [W-1:0] ref_code,
  output logic         below
);
  localparam int EW = W + 2;

  logic [EW-1:0] val_ext, ref_ext, val_lo, ref_hi;
  logic          trip, clear;

  always_comb begin
    val_ext = {2'b00, val};
    ref_ext = {2'b00, ref_code};
    val_lo  = val_ext + EW'(LO_OFS);
    ref_hi  = ref_ext + EW'(HI_OFS);
    trip    = val_lo < ref_ext;
    clear   = val_ext >= ref_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      below <= 1'b0;
    end else if (!hold) begin
      if (!below && trip)      below <= 1'b1;
      else if (below && clear) below <= 1'b0;
    end
  end
endmodule

// File: rtl/bkup_switch_seq.sv
// Break-before-make sequencer for the two switch pairs.
module bkup_switch_seq
  import bkup_pkg::*;
#(
  parameter int NSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           below_rt,
  input  logic           main_lt_bat,
  input  logic           batt_ok,
  output logic [NSW-1:0] main_en,
  output logic [NSW-1:0] bat_en,
  output logic           bkup,
  output logic           bkup_nxt
);
  sw_state_e state_q, state_d;
  logic      main_cl_d, bat_cl_d;
  logic      main_cl_q, bat_cl_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_MAIN:     if (below_rt && main_lt_bat && batt_ok) state_d = ST_BRK_BAT;
      ST_BRK_BAT:  state_d = ST_BATT;
      ST_BATT:     if (!below_rt) state_d = ST_BRK_MAIN;
      ST_BRK_MAIN: state_d = ST_MAIN;
      default:     state_d = ST_MAIN;
    endcase
    main_cl_d = (state_d == ST_MAIN);
    bat_cl_d  = (state_d == ST_BATT);
    bkup_nxt  = (state_d == ST_BRK_BAT) || (state_d == ST_BATT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_MAIN;
      main_cl_q <= 1'b1;
      bat_cl_q  <= 1'b0;
      bkup      <= 1'b0;
    end else begin
      state_q   <= state_d;
      main_cl_q <= main_cl_d;
      bat_cl_q  <= bat_cl_d;
      bkup      <= bkup_nxt;
    end
  end

  for (genvar i = 0; i < NSW; i++) begin : g_pair
    assign main_en[i] = main_cl_q;
    assign bat_en[i]  = bat_cl_q;
  end
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl #(
  parameter int CODE_W   = 10,
  parameter int NSW      = 2,
  parameter int RST_TH   = 930,
  parameter int RST_HYS  = 8,
  parameter int SW_HALF  = 4,
  parameter int BATT_MIN = 200,
  parameter int PF_REF   = 250,
  parameter int PF_HYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] vbat_code,
  input  logic [CODE_W-1:0] pf_code,
  output logic [NSW-1:0]    main_sw_en,
  output logic [NSW-1:0]    bat_sw_en,
  output logic              backup_mode,
  output logic              pf_n
);
  localparam logic [CODE_W-1:0] RT_CODE   = CODE_W'(RST_TH);
  localparam logic [CODE_W-1:0] BMIN_CODE = CODE_W'(BATT_MIN);
  localparam logic [CODE_W-1:0] PF_CODE   = CODE_W'(PF_REF);

  logic below_rt, main_lt_bat, batt_low, pf_low, bkup_nxt;

  bkup_hyst_cmp #(.W(CODE_W), .LO_OFS(0), .HI_OFS(RST_HYS)) u_rt_cmp (
    .clk(clk), .rst(rst), .hold(1'b0), .val(vcc_code), .ref_code(RT_CODE),
    .below(below_rt));

  bkup_hyst_cmp #(.W(CODE_W), .LO_OFS(SW_HALF), .HI_OFS(SW_HALF + 1)) u_sw_cmp (
    .clk(clk), .rst(rst), .hold(1'b0), .val(vcc_code), .ref_code(vbat_code),
    .below(main_lt_bat));

  bkup_hyst_cmp #(.W(CODE_W), .LO_OFS(0), .HI_OFS(0)) u_bmin_cmp (
    .clk(clk), .rst(rst), .hold(1'b0), .val(vbat_code), .ref_code(BMIN_CODE),
    .below(batt_low));

  bkup_hyst_cmp #(.W(CODE_W), .LO_OFS(0), .HI_OFS(PF_HYS)) u_pf_cmp (
    .clk(clk), .rst(rst), .hold(backup_mode), .val(pf_code), .ref_code(PF_CODE),
    .below(pf_low));

  bkup_switch_seq #(.NSW(NSW)) u_seq (
    .clk(clk), .rst(rst), .below_rt(below_rt), .main_lt_bat(main_lt_bat),
    .batt_ok(!batt_low), .main_en(main_sw_en), .bat_en(bat_sw_en),
    .bkup(backup_mode), .bkup_nxt(bkup_nxt));

  always_ff @(posedge clk) begin
    if (rst) pf_n <= 1'b1;
    else     pf_n <= !bkup_nxt && !pf_low;
  end
endmodule

// File: rtl/bkup_switch_chk.sv
module bkup_switch_chk #(
  parameter int CODE_W   = 10,
  parameter int NSW      = 2,
  parameter int RST_TH   = 930,
  parameter int RST_HYS  = 8,
  parameter int BATT_MIN = 200
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] vcc_code,
  input logic [CODE_W-1:0] vbat_code,
  input logic [NSW-1:0]    main_sw_en,
  input logic [NSW-1:0]    bat_sw_en,
  input logic              backup_mode,
  input logic              pf_n
);
  localparam logic [CODE_W+1:0] RT_UP = (CODE_W+2)'(RST_TH + RST_HYS);
  localparam logic [CODE_W+1:0] BMIN  = (CODE_W+2)'(BATT_MIN);

  // R12
  pairs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !((|main_sw_en) && (|bat_sw_en)));

  // R7
  bbm_to_bat_chk: assert property (@(posedge clk) disable iff (rst)
    (|bat_sw_en) |-> !$past(|main_sw_en));

  // R7
  bbm_to_main_chk: assert property (@(posedge clk) disable iff (rst)
    (|main_sw_en) |-> !$past(|bat_sw_en));

  // R10
  pf_forced_chk: assert property (@(posedge clk) disable iff (rst)
    backup_mode |-> !pf_n);

  // R8
  mode_main_open_chk: assert property (@(posedge clk) disable iff (rst)
    backup_mode |-> !(|main_sw_en));

  // R2
  entry_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(backup_mode) |-> (({2'b00, $past(vcc_code, 2)} < RT_UP) &&
                            ({2'b00, $past(vbat_code, 2)} >= BMIN)));

  // R4
  exit_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(backup_mode) |-> ({2'b00, $past(vcc_code, 2)} >= RT_UP));
endmodule

bind bkup_switch_ctrl bkup_switch_chk #(
  .CODE_W(CODE_W), .NSW(NSW), .RST_TH(RST_TH), .RST_HYS(RST_HYS),
  .BATT_MIN(BATT_MIN)
) u_chk (
  .clk(clk), .rst(rst), .vcc_code(vcc_code), .vbat_code(vbat_code),
  .main_sw_en(main_sw_en), .bat_sw_en(bat_sw_en),
  .backup_mode(backup_mode), .pf_n(pf_n));

// File: tb/bkup_switch_ctrl_tb.sv
module bkup_switch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] vcc_code = 10'd1000;
  logic [W-1:0] vbat_code = 10'd600;
  logic [W-1:0] pf_code = 10'd400;
  logic [1:0]   main_sw_en, bat_sw_en;
  logic         backup_mode, pf_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] SW_MAIN = 4'b1100;
  localparam logic [3:0] SW_OPEN = 4'b0000;
  localparam logic [3:0] SW_BATT = 4'b0011;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkup_switch_ctrl dut_i (
    .clk(clk), .rst(rst), .vcc_code(vcc_code), .vbat_code(vbat_code),
    .pf_code(pf_code), .main_sw_en(main_sw_en), .bat_sw_en(bat_sw_en),
    .backup_mode(backup_mode), .pf_n(pf_n));

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  task automatic chk_sw(input string req, input logic [3:0] exp_v);
    chk(req, int'({main_sw_en, bat_sw_en}), int'(exp_v));
    chk("R12", int'((|main_sw_en) && (|bat_sw_en)), 0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    chk_sw("R1 in reset", SW_MAIN);
    chk("R1 flag", int'(backup_mode), 0);
    chk("R1 pf", int'(pf_n), 1);
    rst = 1'b0;
    settle();
    chk_sw("R1 after reset", SW_MAIN);
  endtask

  task automatic t_low_above_bat();
    vcc_code = 10'd800; vbat_code = 10'd600;
    settle();
    chk_sw("R3 main kept", SW_MAIN);
    chk("R3 flag", int'(backup_mode), 0);
  endtask

  task automatic t_dead_backup();
    vcc_code = 10'd100; vbat_code = 10'd150;
    settle();
    chk_sw("R11 low backup", SW_MAIN);
    vbat_code = 10'd0;
    settle();
    chk_sw("R11 grounded backup", SW_MAIN);
    vcc_code = 10'd1000; vbat_code = 10'd1023;
    settle();
    chk_sw("R11 high float, main good", SW_MAIN);
    chk("R11 flag", int'(backup_mode), 0);
  endtask

  task automatic t_enter();
    pf_code = 10'd400;
    vcc_code = 10'd500; vbat_code = 10'd600;
    step();
    chk_sw("R2 edge1 main", SW_MAIN);
    chk("R8 edge1 flag", int'(backup_mode), 0);
    step();
    chk_sw("R7 open into backup", SW_OPEN);
    chk("R8 flag in break", int'(backup_mode), 1);
    chk("R10 pf forced", int'(pf_n), 0);
    step();
    chk_sw("R2 backup closed", SW_BATT);
  endtask

  task automatic t_pf_frozen();
    pf_code = 10'd100;
    settle();
    chk("R10 pf low input", int'(pf_n), 0);
    pf_code = 10'd400;
    settle();
    chk("R10 pf high input", int'(pf_n), 0);
  endtask

  task automatic t_rt_band_exit();
    vcc_code = 10'd935;
    settle();
    chk_sw("R5 band stays backup", SW_BATT);
    vbat_code = 10'd0;
    vcc_code = 10'd937;
    settle();
    chk_sw("R5 top of band", SW_BATT);
    vcc_code = 10'd938;
    step();
    chk_sw("R4 edge1 backup", SW_BATT);
    step();
    chk_sw("R7 open into main", SW_OPEN);
    chk("R8 flag off in break", int'(backup_mode), 0);
    step();
    chk_sw("R4 main closed", SW_MAIN);
    settle();
    chk("R10 pf released", int'(pf_n), 1);
  endtask

  task automatic t_sw_hyst();
    vcc_code = 10'd500; vbat_code = 10'd504;
    settle();
    chk_sw("R6 at margin", SW_MAIN);
    vbat_code = 10'd505;
    settle();
    chk_sw("R6 past margin", SW_BATT);
    vcc_code = 10'd1000;
    settle();
    chk_sw("R4 recovered", SW_MAIN);
  endtask

  task automatic t_pf();
    pf_code = 10'd249;
    step();
    chk("R9 edge1", int'(pf_n), 1);
    step();
    chk("R9 low", int'(pf_n), 0);
    pf_code = 10'd253;
    settle();
    chk("R9 in band", int'(pf_n), 0);
    pf_code = 10'd254;
    settle();
    chk("R9 release", int'(pf_n), 1);
    pf_code = 10'd250;
    settle();
    chk("R9 at ref", int'(pf_n), 1);
  endtask

  initial begin
    t_reset();
    t_low_above_bat();
    t_dead_backup();
    t_enter();
    t_pf_frozen();
    t_rt_band_exit();
    t_sw_hyst();
    t_pf();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule